// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block is the interrupt front end of a general-purpose pin controller. Every pin has a small configuration field that picks one of four trigger styles: rising edge, falling edge, low level or high level. The style is encoded by a trigger-kind bit and a polarity bit. When the chosen condition is seen on an already synchronized pin input, the pin's status bit is set. Software clears status bits by writing ones to a 32-bit status word. A zero in that word leaves the matching bit alone.

The status vector is masked by an enable bitmap to form a per-pin pending vector. The OR of all pending bits is registered and drives a single interrupt request. The enable bitmap and the per-pin configuration bits are held in the neighbouring register block and arrive here as inputs. The status clear arrives as a one-cycle write strobe with a word index and a data word. Detection only runs on pins that are configured as general-purpose inputs and have input sensing switched on.

Top module: `gpio_irq_detect`

## Requirements
- R1: With trigger bit 4 = 0 and polarity bit 3 = 0, a pin's status bit is set on the clock edge after the input changes from 0 to 1. A change from 1 to 0 does not set it.
- R2: With trigger bit 4 = 0 and polarity bit 3 = 1, the status bit is set on the clock edge after the input changes from 1 to 0. A change from 0 to 1 does not set it.
- R3: With trigger bit 4 = 1 and polarity bit 3 = 0, the status bit is set on each clock edge at which the input is 0.
- R4: With trigger bit 4 = 1 and polarity bit 3 = 1, the status bit is set on each clock edge at which the input is 1.
- R5: Each pin has a 5-bit configuration field. Bits [1:0] select the pin's use, and the value 01 means general-purpose. Bit 2 is direction, with 1 meaning input. A pin detects events only when its use is 01, bit 2 is 1 and its sense-off input is 0.
- R6: A clear write with word index w and data d clears status bit i wherever i/32 equals w and bit i%32 of d is 1. Every other status bit keeps its value, including when d is 0.
- R7: When an event and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R8: In a level mode, a clear written while the level is still active leaves the bit set. Once the level has gone inactive, the same clear takes effect.
- R9: The pending output equals status AND enable, with no added delay.
- R10: The interrupt output is 1 exactly one clock after any pending bit is 1, and 0 one clock after all pending bits are 0.
- R11: While reset is active, status and the interrupt output are 0. The first input sample taken after reset is never treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Synchronized pin levels |
| pin_cfg | input | 5*NPINS | Per-pin configuration field: pin i occupies bits [5i+4:5i] |
| sense_off | input | NPINS | Per-pin input-sensing disable |
| irq_en | input | NPINS | Per-pin interrupt enable bitmap |
| clr_we | input | 1 | Status clear write strobe |
| clr_word | input | WSEL | Index of the 32-pin status word being written |
| clr_data | input | WORD | Write-one-to-clear data |
| status | output | NPINS | Latched event status |
| pending | output | NPINS | Status masked by enable |
| irq | output | 1 | Registered combined interrupt request |

## Verification
An event arriving on a pin can fall in the same cycle as a software write that clears that pin's status bit. The bench provokes this on an edge-mode pin by driving the rising input and the clear strobe on the same falling clock edge. It then expects the bit to be set afterwards. The same collision is also provoked with a level-mode pin whose level is held active while its bit is cleared. There the bit is judged to stay set until the level drops, and to clear only on a write made after that.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 40,
  parameter int WORD = 32,
  localparam int NWORDS = (NPINS + WORD - 1) / WORD,
  localparam int WSEL = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_in,
  input  logic [5*NPINS-1:0] pin_cfg,
  input  logic [NPINS-1:0]   sense_off,
  input  logic [NPINS-1:0]   irq_en,
  input  logic               clr_we,
  input  logic [WSEL-1:0]    clr_word,
  input  logic [WORD-1:0]    clr_data,
  output logic [NPINS-1:0]   status,
  output logic [NPINS-1:0]   pending,
  output logic               irq
);

  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] armed;
  logic [NPINS-1:0] evt;
  logic [NPINS-1:0] clr_mask;
  logic             seen;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [4:0] c;
    logic       rise, fall;
    assign c    = pin_cfg[5*i +: 5];
    assign rise = seen && !prev[i] && pin_in[i];
    assign fall = seen && prev[i] && !pin_in[i];
    assign armed[i] = (c[1:0] == 2'b01) && c[2] && !sense_off[i];
    assign evt[i] = armed[i] && (c[4] ? (pin_in[i] == c[3]) : (c[3] ? fall : rise));
    assign clr_mask[i] = clr_we && (clr_word == WSEL'(i / WORD)) && clr_data[i % WORD];
  end

  assign pending = status & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev   <= '0;
      seen   <= 1'b0;
      status <= '0;
      irq    <= 1'b0;
    end else begin
      prev   <= pin_in;
      seen   <= 1'b1;
      status <= (status & ~clr_mask) | evt;
      irq    <= |pending;
    end
  end

endmodule

module gpio_irq_detect_chk #(
  parameter int NPINS = 40,
  parameter int WORD = 32,
  localparam int NWORDS = (NPINS + WORD - 1) / WORD,
  localparam int WSEL = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPINS-1:0]   pin_in,
  input logic [5*NPINS-1:0] pin_cfg,
  input logic [NPINS-1:0]   sense_off,
  input logic [NPINS-1:0]   irq_en,
  input logic               clr_we,
  input logic [WSEL-1:0]    clr_word,
  input logic [WORD-1:0]    clr_data,
  input logic [NPINS-1:0]   status,
  input logic [NPINS-1:0]   pending,
  input logic               irq
);

  logic [NPINS-1:0] ok_pin, wipe, lvl;
  logic up;

  for (genvar i = 0; i < NPINS; i++) begin : g_c
    logic [4:0] f;
    assign f = pin_cfg[5*i +: 5];
    assign ok_pin[i] = f[0] && !f[1] && f[2] && !sense_off[i];
    assign wipe[i] = clr_we && (int'(clr_word) == i / WORD) && clr_data[i % WORD];
    assign lvl[i] = ok_pin[i] && f[4] && (pin_in[i] == f[3]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) up <= 1'b0;
    else        up <= 1'b1;
  end

  assert_set_needs_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> ((status & ~$past(status) & ~$past(ok_pin)) == '0));

  assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> (($past(status) & ~status & ~$past(wipe)) == '0));

  assert_level_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> (($past(lvl) & ~status) == '0));

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> (irq == $past(|pending)));

  assert_pending_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    up |-> ((pending & ~irq_en) == '0));

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .WORD(WORD)) u_chk (.*);

// File: tb/sim_gpio_irq_detect.sv
module sim_gpio_irq_detect;
  localparam int PERIOD = 10;
  localparam int NP = 40;
  localparam int WD = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pin_in = '0;
  logic [5*NP-1:0] pin_cfg;
  logic [NP-1:0]   sense_off = '0;
  logic [NP-1:0]   irq_en = '0;
  logic            clr_we = 1'b0;
  logic [0:0]      clr_word = '0;
  logic [WD-1:0]   clr_data = '0;
  logic [NP-1:0]   status, pending;
  logic            irq;
  logic [4:0]      cfg [NP];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < NP; i++) pin_cfg[5*i +: 5] = cfg[i];

  gpio_irq_detect #(.NPINS(NP), .WORD(WD)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_cfg(pin_cfg),
    .sense_off(sense_off), .irq_en(irq_en), .clr_we(clr_we),
    .clr_word(clr_word), .clr_data(clr_data), .status(status),
    .pending(pending), .irq(irq));

  function automatic logic [4:0] mk(input logic trig, input logic inv);
    return {trig, inv, 1'b1, 2'b01};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr(input int w, input logic [WD-1:0] d);
    clr_we = 1'b1; clr_word = 1'(w); clr_data = d;
    step();
    clr_we = 1'b0; clr_data = '0;
  endtask

  task automatic t_reset();
    cfg[3] = mk(1'b0, 1'b0);
    pin_in[3] = 1'b1;
    step(); step();
    chk("R11 status in reset", 64'(status), 64'h0);
    chk("R11 irq in reset", 64'(irq), 64'h0);
    rst_n = 1'b1;
    step(); step();
    chk("R11 no edge on first sample", 64'(status[3]), 64'h0);
    cfg[3] = '0; pin_in[3] = 1'b0;
    step();
  endtask

  task automatic t_rise();
    cfg[5] = mk(1'b0, 1'b0); irq_en[5] = 1'b1;
    step();
    pin_in[5] = 1'b1; step();
    chk("R1 rising sets", 64'(status[5]), 64'h1);
    chk("R9 pending follows", 64'(pending[5]), 64'h1);
    chk("R10 irq not yet", 64'(irq), 64'h0);
    step();
    chk("R10 irq one clock later", 64'(irq), 64'h1);
    clr(0, WD'(1) << 5);
    chk("R6 cleared", 64'(status[5]), 64'h0);
    chk("R10 irq still high", 64'(irq), 64'h1);
    step();
    chk("R10 irq drops", 64'(irq), 64'h0);
    pin_in[5] = 1'b0; step();
    chk("R1 falling ignored", 64'(status[5]), 64'h0);
    cfg[5] = '0; irq_en[5] = 1'b0;
  endtask

  task automatic t_fall();
    cfg[7] = mk(1'b0, 1'b1);
    step();
    pin_in[7] = 1'b1; step();
    chk("R2 rising ignored", 64'(status[7]), 64'h0);
    pin_in[7] = 1'b0; step();
    chk("R2 falling sets", 64'(status[7]), 64'h1);
    clr(0, WD'(1) << 7);
    cfg[7] = '0;
  endtask

  task automatic t_low();
    pin_in[33] = 1'b1; cfg[33] = mk(1'b1, 1'b0);
    step();
    chk("R3 high level idle", 64'(status[33]), 64'h0);
    pin_in[33] = 1'b0; step();
    chk("R3 low level sets", 64'(status[33]), 64'h1);
    clr(1, WD'(1) << 1);
    chk("R8 clear while active", 64'(status[33]), 64'h1);
    pin_in[33] = 1'b1; step();
    chk("R8 held after release", 64'(status[33]), 64'h1);
    clr(1, WD'(1) << 1);
    chk("R8 clear after release", 64'(status[33]), 64'h0);
    cfg[33] = '0; pin_in[33] = 1'b0;
  endtask

  task automatic t_high();
    cfg[10] = mk(1'b1, 1'b1);
    step();
    chk("R4 low level idle", 64'(status[10]), 64'h0);
    pin_in[10] = 1'b1; step();
    chk("R4 high level sets", 64'(status[10]), 64'h1);
    pin_in[10] = 1'b0; step();
    clr(0, WD'(1) << 10);
    chk("R4 cleared once low", 64'(status[10]), 64'h0);
    cfg[10] = '0;
  endtask

  task automatic t_gate();
    cfg[12] = 5'b00100;
    pin_in[12] = 1'b1; step(); pin_in[12] = 1'b0; step();
    chk("R5 native use blocks", 64'(status[12]), 64'h0);
    cfg[12] = 5'b00001;
    pin_in[12] = 1'b1; step(); pin_in[12] = 1'b0; step();
    chk("R5 output dir blocks", 64'(status[12]), 64'h0);
    cfg[12] = mk(1'b0, 1'b0); sense_off[12] = 1'b1;
    pin_in[12] = 1'b1; step(); pin_in[12] = 1'b0; step();
    chk("R5 sense off blocks", 64'(status[12]), 64'h0);
    sense_off[12] = 1'b0;
    pin_in[12] = 1'b1; step();
    chk("R5 armed detects", 64'(status[12]), 64'h1);
    pin_in[12] = 1'b0; step();
    clr(0, WD'(1) << 12);
    cfg[12] = '0;
  endtask

  task automatic t_w1c();
    cfg[0] = mk(1'b0, 1'b0); cfg[1] = mk(1'b0, 1'b0);
    step();
    pin_in[1:0] = 2'b11; step();
    chk("R6 both set", 64'(status[1:0]), 64'h3);
    clr(0, 32'h0);
    chk("R6 zero write keeps", 64'(status[1:0]), 64'h3);
    clr(1, 32'h1);
    chk("R6 other word keeps", 64'(status[1:0]), 64'h3);
    clr(0, 32'h2);
    chk("R6 one bit cleared", 64'(status[1:0]), 64'h1);
    clr(0, 32'hffff_ffff);
    chk("R6 all cleared", 64'(status), 64'h0);
    cfg[0] = '0; cfg[1] = '0; pin_in[1:0] = 2'b00;
    step();
  endtask

  task automatic t_collide();
    cfg[2] = mk(1'b0, 1'b0);
    step();
    pin_in[2] = 1'b1;
    clr(0, WD'(1) << 2);
    chk("R7 event beats clear", 64'(status[2]), 64'h1);
    clr(0, WD'(1) << 2);
    chk("R7 later clear works", 64'(status[2]), 64'h0);
    cfg[2] = '0; pin_in[2] = 1'b0;
    step();
  endtask

  task automatic t_mask();
    cfg[20] = mk(1'b0, 1'b0);
    step();
    pin_in[20] = 1'b1; step(); step();
    chk("R9 masked pending", 64'(pending), 64'h0);
    chk("R10 masked no irq", 64'(irq), 64'h0);
    irq_en[20] = 1'b1; #1;
    chk("R9 enable exposes", 64'(pending), 64'h1 << 20);
    step();
    chk("R10 irq after enable", 64'(irq), 64'h1);
    irq_en[20] = 1'b0; step();
    chk("R10 irq after disable", 64'(irq), 64'h0);
    chk("R9 status kept", 64'(status[20]), 64'h1);
    clr(0, WD'(1) << 20);
    cfg[20] = '0; pin_in[20] = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) cfg[i] = '0;
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_low();
    t_high();
    t_gate();
    t_w1c();
    t_collide();
    t_mask();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule